// File: doc/BRIEF.md
# Static frame replay buffer

This block keeps one short transmit frame and plays it back as often as a consumer asks. A producer pushes the frame in one byte per handshake, marking the first byte with a start flag and the final byte with an end flag. Each time the consumer pulses a request, the block streams the stored bytes from the first to the last, flagging the final one. A readout does not consume the frame, so the same content can be sent again and again until a producer replaces it.

Storage is two banks used in turn. An incoming frame is always written into the bank that readers are not using. The stored frame switches to the new bank only once the end flag has been taken. A frame that grows past the size limit is discarded and reported, and the previous frame stays in place. When a frame completes while a readout is running, the switch is deferred until that readout has ended, and the write side stalls in the meantime.

The write controller has four states. `W_IDLE` waits for a start byte. `W_FILL` collects bytes. `W_DROP` swallows the rest of an oversize frame. `W_HOLD` waits for a readout to finish so the frame can be committed. Its transitions are:
- start: `W_IDLE`→`W_FILL` on a start byte without an end flag.
- finish: `W_FILL`→`W_IDLE`, or `W_IDLE`→`W_IDLE` for a one-byte frame, on an end byte while no readout runs.
- defer: to `W_HOLD` on an end byte while a readout runs.
- overflow: `W_FILL`→`W_DROP` on a byte past the limit.
- reject: `W_DROP`/`W_FILL`→`W_IDLE` on the end byte of an oversize frame.
- release: `W_HOLD`→`W_IDLE` once the reader is idle.

The read controller has two states. `R_IDLE` waits for a request. `R_STREAM` presents bytes. Its transitions are:
- launch: `R_IDLE`→`R_STREAM` on a request while a frame is held.
- refuse: stay in `R_IDLE` and raise the empty pulse when no frame is held.
- drain: `R_STREAM`→`R_IDLE` when the last byte is taken.

Top module: `sfr_static_frame_buf`

## Requirements
- R1: After reset, `frame_valid` is 0, `frame_len` is 0, `rd_valid` is 0, `wr_ready` is 1, and both `wr_oversize` and `rd_empty` are 0.
- R2: A byte taken with `wr_sof`=1 starts a frame, and a byte taken with `wr_eof`=1 ends it. In the cycle after the end byte is taken (when no readout is running), `frame_len` equals the number of bytes and `frame_valid` is 1. `frame_valid` never returns to 0 after that.
- R3: A one-cycle pulse on `rd_req` in the idle read state starts a readout in the next cycle. Bytes 0 to `frame_len`-1 appear in order on `rd_data` with `rd_valid`=1, one per cycle in which `rd_ready`=1, and `rd_last`=1 only on the final byte. While `rd_ready`=0, the byte and `rd_last` hold.
- R4: A readout does not remove the frame. Repeated readouts return identical bytes.
- R5: A newly completed frame replaces the stored one. Later readouts return only the new bytes and length.
- R6: A frame of up to `MAX_BYTES` (252) bytes is accepted. For a frame of 253 or more bytes, `wr_oversize` pulses high for exactly one cycle, in the cycle after its end byte is taken. The stored frame and `frame_len` are left unchanged.
- R7: While a new frame has been started but its end byte has not been taken, readouts return the previously stored frame.
- R8: A request while no frame has ever been stored produces no `rd_valid`. Instead, `rd_empty` is 1 for exactly the next cycle.
- R9: If a frame's end byte is taken during a readout, `wr_ready` drops to 0 and `frame_len` stays unchanged until that readout has ended. The new frame is then committed.
- R10: A byte offered with `wr_sof`=0 while no frame is being collected is discarded and leaves the stored frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Producer offers a byte |
| wr_ready | output | 1 | Block can take a byte (low while a commit waits) |
| wr_data | input | 8 | Byte to write |
| wr_sof | input | 1 | Offered byte is the first of a frame |
| wr_eof | input | 1 | Offered byte is the last of a frame |
| wr_oversize | output | 1 | One-cycle pulse: the finished frame exceeded the limit and was dropped |
| rd_req | input | 1 | Pulse to request one readout |
| rd_valid | output | 1 | A byte of the readout is presented |
| rd_ready | input | 1 | Consumer takes the presented byte |
| rd_data | output | 8 | Presented byte |
| rd_last | output | 1 | Presented byte is the final one |
| rd_empty | output | 1 | One-cycle pulse: a request found no stored frame |
| frame_len | output | 8 | Length in bytes of the stored frame |
| frame_valid | output | 1 | A frame is stored |

## Verification
The assertions assume that the producer holds each offered byte until it is taken, and that the consumer pulses `rd_req` only while no readout is being presented. They also assume that `rd_ready` may stall at any time. The stimulus therefore drives requests only between readouts, and it drives every byte at the falling edge and holds it until `wr_ready` lets it in. One readout runs with `rd_ready` stalled every third byte, so the hold-under-stall property is exercised. The write that overlaps a readout is started only after that readout has begun. This places its end byte squarely inside the stream, on the path that defers the commit.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FILL,
        W_DROP,
        W_HOLD
    } wr_state_e;

    typedef enum logic {
        R_IDLE,
        R_STREAM
    } rd_state_e;

endpackage

// File: rtl/sfr_frame_store.sv
module sfr_frame_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 252,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int NBANK = 2;

    logic [DATA_W-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wbank == b[0])) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_rd[b] = mem[raddr];
    end

    assign rdata = bank_rd[rbank];

endmodule

// File: rtl/sfr_write_ctl.sv
module sfr_write_ctl
    import sfr_pkg::*;
#(
    parameter int MAX_BYTES = 252,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1),
    parameter int ADDR_W    = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_sof,
    input  logic              wr_eof,
    input  logic              rd_busy,
    output logic              wr_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              commit,
    output logic [CNT_W-1:0]  commit_len,
    output logic              oversize
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BYTES);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    wr_state_e        state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W-1:0] pend_len, pend_nxt;
    logic             ovf_q, ovf_nxt;
    logic             take;
    logic             fin;
    logic [CNT_W-1:0] fin_len;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            cnt      <= '0;
            pend_len <= '0;
            ovf_q    <= 1'b0;
        end else begin
            state    <= state_nxt;
            cnt      <= cnt_nxt;
            pend_len <= pend_nxt;
            ovf_q    <= ovf_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt  = state;
        cnt_nxt    = cnt;
        pend_nxt   = pend_len;
        ovf_nxt    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = ADDR_W'(cnt);
        commit     = 1'b0;
        commit_len = pend_len;
        fin        = 1'b0;
        fin_len    = cnt;
        wr_ready   = (state != W_HOLD);
        take       = wr_valid && wr_ready;

        unique case (state)
            W_IDLE: begin
                if (take && wr_sof) begin
                    mem_we   = 1'b1;
                    mem_addr = '0;
                    cnt_nxt  = ONE;
                    if (wr_eof) begin
                        fin     = 1'b1;
                        fin_len = ONE;
                    end else begin
                        state_nxt = W_FILL;
                    end
                end
            end
            W_FILL: begin
                if (take) begin
                    if (wr_sof) begin
                        mem_we   = 1'b1;
                        mem_addr = '0;
                        cnt_nxt  = ONE;
                        if (wr_eof) begin
                            fin     = 1'b1;
                            fin_len = ONE;
                        end
                    end else if (cnt == LIMIT) begin
                        if (wr_eof) begin
                            ovf_nxt   = 1'b1;
                            state_nxt = W_IDLE;
                        end else begin
                            state_nxt = W_DROP;
                        end
                    end else begin
                        mem_we  = 1'b1;
                        cnt_nxt = cnt + ONE;
                        if (wr_eof) begin
                            fin     = 1'b1;
                            fin_len = cnt + ONE;
                        end
                    end
                end
            end
            W_DROP: begin
                if (take && wr_eof) begin
                    ovf_nxt   = 1'b1;
                    state_nxt = W_IDLE;
                end
            end
            W_HOLD: begin
                if (!rd_busy) begin
                    commit     = 1'b1;
                    commit_len = pend_len;
                    state_nxt  = W_IDLE;
                end
            end
        endcase

        if (fin) begin
            if (rd_busy) begin
                pend_nxt  = fin_len;
                state_nxt = W_HOLD;
            end else begin
                commit     = 1'b1;
                commit_len = fin_len;
                state_nxt  = W_IDLE;
            end
        end
    end

    assign oversize = ovf_q;

endmodule

// File: rtl/sfr_read_ctl.sv
module sfr_read_ctl
    import sfr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_ready,
    input  logic              start_ok,
    input  logic              start_bank,
    input  logic [CNT_W-1:0]  start_len,
    output logic              rd_valid,
    output logic              rd_last,
    output logic              rd_busy,
    output logic              rd_bank,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_empty
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    rd_state_e        state, state_nxt;
    logic [CNT_W-1:0] ptr, ptr_nxt;
    logic [CNT_W-1:0] len_q, len_nxt;
    logic             bank_q, bank_nxt;
    logic             empty_q, empty_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= R_IDLE;
            ptr     <= '0;
            len_q   <= '0;
            bank_q  <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            state   <= state_nxt;
            ptr     <= ptr_nxt;
            len_q   <= len_nxt;
            bank_q  <= bank_nxt;
            empty_q <= empty_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        ptr_nxt   = ptr;
        len_nxt   = len_q;
        bank_nxt  = bank_q;
        empty_nxt = 1'b0;
        rd_valid  = (state == R_STREAM);
        rd_last   = rd_valid && (ptr == len_q - ONE);

        unique case (state)
            R_IDLE: begin
                if (rd_req) begin
                    if (start_ok) begin
                        state_nxt = R_STREAM;
                        ptr_nxt   = '0;
                        len_nxt   = start_len;
                        bank_nxt  = start_bank;
                    end else begin
                        empty_nxt = 1'b1;
                    end
                end
            end
            R_STREAM: begin
                if (rd_ready) begin
                    if (rd_last) begin
                        state_nxt = R_IDLE;
                    end else begin
                        ptr_nxt = ptr + ONE;
                    end
                end
            end
        endcase
    end

    assign rd_busy  = (state == R_STREAM);
    assign rd_bank  = bank_q;
    assign rd_addr  = ADDR_W'(ptr);
    assign rd_empty = empty_q;

endmodule

// File: rtl/sfr_static_frame_buf.sv
module sfr_static_frame_buf #(
    parameter int  MAX_BYTES = 252,
    parameter int  DATA_W    = 8,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sof,
    input  logic              wr_eof,
    output logic              wr_oversize,
    input  logic              rd_req,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              rd_empty,
    output logic [LEN_W-1:0]  frame_len,
    output logic              frame_valid
);

    localparam int ADDR_W = $clog2(MAX_BYTES);

    logic              act_bank;
    logic [LEN_W-1:0]  len_q;
    logic              valid_q;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic              commit;
    logic [LEN_W-1:0]  commit_len;
    logic              rd_busy;
    logic              rd_bank;
    logic [ADDR_W-1:0] rd_addr;
    logic              start_ok;
    logic              start_bank;
    logic [LEN_W-1:0]  start_len;

    sfr_write_ctl #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (LEN_W),
        .ADDR_W    (ADDR_W)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_sof     (wr_sof),
        .wr_eof     (wr_eof),
        .rd_busy    (rd_busy),
        .wr_ready   (wr_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_waddr),
        .commit     (commit),
        .commit_len (commit_len),
        .oversize   (wr_oversize)
    );

    // a commit in the same cycle as a request hands the new frame to the reader
    assign start_ok   = valid_q | commit;
    assign start_bank = commit ? ~act_bank : act_bank;
    assign start_len  = commit ? commit_len : len_q;

    sfr_read_ctl #(
        .CNT_W  (LEN_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .rd_ready   (rd_ready),
        .start_ok   (start_ok),
        .start_bank (start_bank),
        .start_len  (start_len),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .rd_busy    (rd_busy),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .rd_empty   (rd_empty)
    );

    sfr_frame_store #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_BYTES),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .wbank (~act_bank),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .rbank (rd_bank),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // committed frame descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_bank <= 1'b0;
            len_q    <= '0;
            valid_q  <= 1'b0;
        end else if (commit) begin
            act_bank <= ~act_bank;
            len_q    <= commit_len;
            valid_q  <= 1'b1;
        end
    end

    assign frame_len   = len_q;
    assign frame_valid = valid_q;

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
    parameter int  MAX_BYTES = 252,
    parameter int  DATA_W    = 8,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ready,
    input logic              wr_oversize,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_last,
    input logic              rd_empty,
    input logic [LEN_W-1:0]  frame_len,
    input logic              frame_valid
);

    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_BYTES);

    a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_len != '0 && frame_len <= LIMIT));

    a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(frame_valid));

    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

    a_r3_last_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    a_r6_oversize_keeps_len: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oversize |-> $stable(frame_len));

    a_r8_empty_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |-> (!rd_valid && !frame_valid));

    a_r9_len_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !(rd_ready && rd_last)) |=> $stable(frame_len));

    a_r9_stall_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> frame_valid);

endmodule

bind sfr_static_frame_buf sfr_checker #(
    .MAX_BYTES (MAX_BYTES),
    .DATA_W    (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ready    (wr_ready),
    .wr_oversize (wr_oversize),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .rd_last     (rd_last),
    .rd_empty    (rd_empty),
    .frame_len   (frame_len),
    .frame_valid (frame_valid)
);

// File: tb/tb_sfr_static_frame_buf.sv
module tb_sfr_static_frame_buf;

    localparam int CLK_P = 10;
    localparam int MAXB  = 252;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [7:0] wr_data = '0;
    logic       wr_sof = 1'b0;
    logic       wr_eof = 1'b0;
    logic       wr_oversize;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic       rd_ready = 1'b1;
    logic [7:0] rd_data;
    logic       rd_last;
    logic       rd_empty;
    logic [7:0] frame_len;
    logic       frame_valid;

    int vecs = 0;
    int bad  = 0;
    logic last_ovf;

    sfr_static_frame_buf #(.MAX_BYTES(MAXB), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_oversize(wr_oversize),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_last(rd_last), .rd_empty(rd_empty),
        .frame_len(frame_len), .frame_valid(frame_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(logic [7:0] d, bit s, bit e);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_sof = s; wr_eof = e;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic write_frame(int len, int seed);
        for (int i = 0; i < len; i++) send_byte(pat(seed, i), i == 0, i == len - 1);
        @(negedge clk);
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
        last_ovf = wr_oversize;
    endtask

    task automatic read_frame(int len, int seed, bit stall, string req);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (stall && (i % 3 == 1)) begin
                rd_ready = 1'b0;
                @(negedge clk);
                chk(rd_valid && rd_data == pat(seed, i), "R3 stall", int'(rd_data), int'(pat(seed, i)));
                rd_ready = 1'b1;
            end
            chk(rd_valid && rd_data == pat(seed, i) && rd_last == (i == len - 1),
                req, int'(rd_data), int'(pat(seed, i)));
            @(negedge clk);
        end
        chk(!rd_valid, "R3 end", int'(rd_valid), 0);
    endtask

    initial begin
        #(CLK_P * 190000);
        bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!frame_valid && frame_len == 0 && !rd_valid && wr_ready && !wr_oversize && !rd_empty,
            "R1", int'(frame_len), 0);

        // R8 request with nothing stored
        rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk(rd_empty && !rd_valid, "R8 pulse", int'(rd_empty), 1);
        @(negedge clk);
        chk(!rd_empty && !rd_valid, "R8 once", int'(rd_empty), 0);

        // R2/R3/R4/R5/R6 sweep over every legal length
        for (int len = 1; len <= MAXB; len++) begin
            write_frame(len, len);
            chk(frame_len == 8'(len) && frame_valid, "R2 len", int'(frame_len), len);
            chk(!last_ovf, "R6 legal", int'(last_ovf), 0);
            read_frame(len, len, (len == 17 || len == MAXB), "R5 replace");
            if (len % 63 == 0) read_frame(len, len, 1'b0, "R4 replay");
        end

        // R6 oversize by one and by several
        write_frame(MAXB + 1, 500);
        chk(last_ovf, "R6 flag", int'(last_ovf), 1);
        chk(frame_len == 8'(MAXB), "R6 keep", int'(frame_len), MAXB);
        @(negedge clk);
        chk(!wr_oversize, "R6 single", int'(wr_oversize), 0);
        write_frame(MAXB + 8, 501);
        chk(last_ovf, "R6 drop", int'(last_ovf), 1);
        read_frame(MAXB, MAXB, 1'b0, "R6 old");

        // R9 write completing during a readout
        write_frame(30, 600);
        fork
            read_frame(30, 600, 1'b0, "R9 read");
            begin
                repeat (3) @(negedge clk);
                write_frame(5, 601);
                chk(!wr_ready, "R9 stall", int'(wr_ready), 0);
                chk(frame_len == 8'd30, "R9 len", int'(frame_len), 30);
            end
        join
        @(negedge clk);
        chk(frame_len == 8'd5 && wr_ready, "R9 commit", int'(frame_len), 5);
        read_frame(5, 601, 1'b0, "R9 new");

        // R7 partial frame stays hidden
        for (int i = 0; i < 4; i++) send_byte(pat(602, i), i == 0, 1'b0);
        @(negedge clk); wr_valid = 1'b0;
        read_frame(5, 601, 1'b0, "R7 old");
        chk(frame_len == 8'd5, "R7 len", int'(frame_len), 5);
        for (int i = 4; i < 8; i++) send_byte(pat(602, i), 1'b0, i == 7);
        @(negedge clk); wr_valid = 1'b0; wr_eof = 1'b0;
        chk(frame_len == 8'd8, "R7 done", int'(frame_len), 8);
        read_frame(8, 602, 1'b0, "R7 new");

        // R10 stray byte without start marker
        send_byte(8'hAA, 1'b0, 1'b1);
        @(negedge clk); wr_valid = 1'b0; wr_eof = 1'b0;
        chk(frame_len == 8'd8 && frame_valid, "R10 len", int'(frame_len), 8);
        read_frame(8, 602, 1'b0, "R10 data");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule